// File: doc/BRIEF.md
# Vectored Interrupt Controller with Return-Stack Guard

This block gathers the interrupt sources of a small 8-bit core: one external interrupt line that is active on a falling edge, and one or two timer overflow pulses. Each event is captured in a request flag of an 8-bit control register. That register also holds a global enable and one enable per source, and software can read and write it. When a pending, enabled request exists, the global enable is set and the core's return stack has room, the block issues a one-cycle acknowledge together with a fixed vector address. The core then pushes its program counter and jumps. Nothing else is saved.

Taking an interrupt clears the global enable and the serviced flag. Nesting therefore happens only when the service routine sets the enable again. The return-from-interrupt strobe sets it again. While the stack is full, requests stay pending and the acknowledge is withheld until the stack has room. A wake-up output tells a halted core that some enabled request is pending, whatever the global enable and the stack state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high-to-low transition on `ext_irq_n_i` sets the external flag (register bit 4) exactly three clock edges after the first edge that sees the low level. A rising edge or a steady level sets nothing.
- R2: A one-cycle pulse on `tmr_ovf_i[k]` sets timer flag k (bit 5 for timer 0, bit 6 for timer 1) at the next clock edge.
- R3: A decision to acknowledge is made in a cycle only if all of these hold: the global enable (bit 0) is 1, some flag has its enable set (bit 1 external, bit 2 timer 0, bit 3 timer 1), `stack_full_i` is 0, and neither `reg_we_i` nor `reti_i` is active. `ack_o` is high for exactly the cycle after that decision.
- R4: The clock edge that raises `ack_o` also clears the global enable and the serviced flag, so `ack_o` never lasts two cycles in a row.
- R5: `vector_o` is 0x004 for the external source, 0x008 for timer 0 and 0x00C for timer 1 while `ack_o` is high, and 0 otherwise.
- R6: When several enabled requests are pending, the external request is served first, then timer 0, then timer 1.
- R7: Requests that arrive while the global enable or their own enable is 0 are still recorded in their flags.
- R8: While `stack_full_i` is 1 no acknowledge is issued and the pending flag is kept. The first decision cycle after `stack_full_i` falls serves it.
- R9: A pulse on `reti_i` sets the global enable at the next edge.
- R10: `wake_o` is 1 whenever some flag and its own enable are both 1, regardless of the global enable and `stack_full_i`.
- R11: A register write loads the global enable, the enables and the flags from `reg_wdata_i`. Bit 7, and the bits of an absent timer 1, always read 0. A source event in the same cycle as a write sets its flag anyway.
- R12: After reset the register reads 0, and `ack_o`, `vector_o` and `wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_irq_n_i | input | 1 | External interrupt line, falling edge active, asynchronous |
| tmr_ovf_i | input | NUM_TIMERS | Timer overflow pulses, one cycle each |
| stack_full_i | input | 1 | Core return stack has no free level |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reg_rdata_o | output | 8 | Control register contents |
| ack_o | output | 1 | Interrupt acknowledge, one cycle |
| vector_o | output | VEC_W | Service address, valid with `ack_o` |
| wake_o | output | 1 | Wake-up request for halt mode |

## Verification
The bench builds the block with its defaults: two timers, 13-bit vectors and a two-flop synchroniser. With two timers present, the three-way priority, the 0x00C vector and bit 6 can all be reached. The bench runs a cycle model of the register, the synchroniser pipeline and the decision alongside the block. Directed sequences walk through the priority order, the stack hold-off and re-enabling by return. A long random phase then mixes writes, returns, stack-full stretches, pin toggles and timer pulses that collide with acknowledges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W   = 8;
  localparam int GIE_BIT = 0;
  localparam int EN_LSB  = 1;
  localparam int FLG_LSB = 4;
  localparam int MAX_SRC = 3;

  // Source k vectors to 4*(k+1): external 0x004, timer0 0x008, timer1 0x00C
  function automatic int vec_of(input int idx);
    return 4 * (idx + 1);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  // R1
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 3,
  parameter int VEC_W = 13
) (
  input  logic [NSRC-1:0]  pend_i,
  output logic [NSRC-1:0]  grant_o,
  output logic [VEC_W-1:0] vec_o
);
  import irq_pkg::*;

  logic found;

  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    found   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && !found) begin
        grant_o[i] = 1'b1;
        vec_o      = VEC_W'(vec_of(i));
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int NSRC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [irq_pkg::REG_W-1:0] wdata_i,
  input  logic                     reti_i,
  input  logic                     take_i,
  input  logic [NSRC-1:0]          grant_i,
  input  logic [NSRC-1:0]          set_i,
  output logic                     gie_o,
  output logic [NSRC-1:0]          en_o,
  output logic [NSRC-1:0]          flag_o,
  output logic [irq_pkg::REG_W-1:0] rdata_o
);
  import irq_pkg::*;

  logic            gie_q, gie_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] flag_q, flag_d;
  logic            base_gie;
  logic [NSRC-1:0] base_en, base_flag;

  always_comb begin
    base_gie = we_i ? wdata_i[GIE_BIT] : gie_q;
    for (int i = 0; i < NSRC; i++) begin
      base_en[i]   = we_i ? wdata_i[EN_LSB + i]  : en_q[i];
      base_flag[i] = we_i ? wdata_i[FLG_LSB + i] : flag_q[i];
    end
    gie_d = base_gie;
    if (reti_i) gie_d = 1'b1;
    if (take_i) gie_d = 1'b0;
    en_d   = base_en;
    flag_d = (base_flag & ~({NSRC{take_i}} & grant_i)) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[GIE_BIT] = gie_q;
    for (int i = 0; i < NSRC; i++) begin
      rdata_o[EN_LSB + i]  = en_q[i];
      rdata_o[FLG_LSB + i] = flag_q[i];
    end
  end

  assign gie_o  = gie_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R1 R2 R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);
  end

  // R4
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !gie_o);

  // R9
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !we_i) |=> gie_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_TIMERS  = 2,
  parameter int VEC_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_irq_n_i,
  input  logic [NUM_TIMERS-1:0] tmr_ovf_i,
  input  logic                  stack_full_i,
  input  logic                  reg_we_i,
  input  logic [7:0]            reg_wdata_i,
  input  logic                  reti_i,
  output logic [7:0]            reg_rdata_o,
  output logic                  ack_o,
  output logic [VEC_W-1:0]      vector_o,
  output logic                  wake_o
);
  import irq_pkg::*;

  localparam int NSRC = 1 + NUM_TIMERS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic            ext_fall;
  logic [NSRC-1:0] set_vec;
  logic            gie;
  logic [NSRC-1:0] en, flag, pend, grant;
  logic [VEC_W-1:0] arb_vec;
  logic            take;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (ext_irq_n_i),
    .fall_o (ext_fall)
  );

  assign set_vec = {tmr_ovf_i, ext_fall};

  irq_ctrl_reg #(.NSRC(NSRC)) u_reg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .reti_i  (reti_i),
    .take_i  (take),
    .grant_i (grant),
    .set_i   (set_vec),
    .gie_o   (gie),
    .en_o    (en),
    .flag_o  (flag),
    .rdata_o (reg_rdata_o)
  );

  assign pend = flag & en;

  irq_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .pend_i  (pend),
    .grant_o (grant),
    .vec_o   (arb_vec)
  );

  assign take = gie & (|pend) & ~stack_full_i & ~reg_we_i & ~reti_i;

  logic             ack_q, ack_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    ack_d = take;
    vec_d = take ? arb_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_d;
      vec_q <= vec_d;
    end
  end

  assign ack_o    = ack_q;
  assign vector_o = vec_q;
  assign wake_o   = |pend;

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_o |=> !ack_o);
  // R4
  ack_gie_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_o |-> !gie);
  // R3
  ack_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_o |-> $past(gie));
  // R8
  stack_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    stack_full_i |=> !ack_o);
  // R5
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_o |-> (vector_o[1:0] == 2'b00 && vector_o != '0));
  // R5
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ack_o |-> (vector_o == '0));
  // R10
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wake_o |-> (|flag));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MASK = 8'h7F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin;
  logic [1:0]  tov;
  logic        sf, we, reti;
  logic [7:0]  wd;
  logic [7:0]  rdata;
  logic        ack, wake;
  logic [12:0] vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [7:0]  m_reg;
  logic        m_ack;
  logic [12:0] m_vec;
  logic        m_s1, m_s2, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n_i(pin), .tmr_ovf_i(tov),
    .stack_full_i(sf), .reg_we_i(we), .reg_wdata_i(wd), .reti_i(reti),
    .reg_rdata_o(rdata), .ack_o(ack), .vector_o(vector), .wake_o(wake)
  );

  function automatic logic [1:0] pick(input logic [2:0] p);
    if (p[0]) return 2'd0;
    if (p[1]) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [12:0] vec_for(input logic [1:0] s);
    return 13'(4 * (int'(s) + 1));
  endfunction

  function automatic logic exp_wake(input logic [7:0] r);
    return |(r[6:4] & r[3:1]);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    logic [2:0]  pend;
    logic        dec;
    logic [1:0]  s;
    logic [7:0]  n;
    logic        fall;
    pend = m_reg[6:4] & m_reg[3:1];
    dec  = m_reg[0] & (|pend) & !sf & !we & !reti;
    s    = pick(pend);
    n    = we ? (wd & MASK) : m_reg;
    if (reti) n[0] = 1'b1;
    if (dec) begin
      n[0]     = 1'b0;
      n[4 + s] = 1'b0;
    end
    fall = m_prev & ~m_s2;
    n[4] = n[4] | fall;
    n[5] = n[5] | tov[0];
    n[6] = n[6] | tov[1];
    @(negedge clk);
    m_reg  = n & MASK;
    m_ack  = dec;
    m_vec  = dec ? vec_for(s) : 13'd0;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pin;
    check("R3 ack", 16'(ack), 16'(m_ack));
    check("R5 vector", 16'(vector), 16'(m_vec));
    check("R11 register", 16'(rdata), 16'(m_reg));
    check("R10 wake", 16'(wake), 16'(exp_wake(m_reg)));
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; pin = 1; tov = 0; sf = 0; we = 0; wd = 0; reti = 0;
    m_reg = 0; m_ack = 0; m_vec = 0; m_s1 = 1; m_s2 = 1; m_prev = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 register", 16'(rdata), 16'h0);
    check("R12 ack", 16'(ack), 16'h0);
    check("R12 vector", 16'(vector), 16'h0);
    check("R12 wake", 16'(wake), 16'h0);

    // R11 bit 7 reads zero
    we = 1; wd = 8'h80; cycle();
    check("R11 bit7", 16'(rdata), 16'h00);
    wd = 8'h0E; cycle(); we = 0;

    // R2 R7 timer0 flag with global enable off
    tov = 2'b01; cycle(); tov = 0;
    check("R2 timer0 flag", 16'(rdata[5]), 16'h1);
    check("R7 no ack while blocked", 16'(ack), 16'h0);
    check("R10 wake blocked", 16'(wake), 16'h1);

    // R1 external falling edge latency
    pin = 0; cycles(2);
    check("R1 not yet", 16'(rdata[4]), 16'h0);
    cycle();
    check("R1 ext flag", 16'(rdata[4]), 16'h1);
    cycles(2); pin = 1; cycles(4);
    check("R1 rising ignored", 16'(rdata), 16'h3E);

    // R6 priority, R4 clear on ack
    we = 1; wd = 8'h7F; cycle(); we = 0;
    cycle();
    check("R6 ack", 16'(ack), 16'h1);
    check("R6 ext first", 16'(vector), 16'h004);
    check("R4 cleared", 16'(rdata), 16'h6E);
    cycle();
    check("R4 single pulse", 16'(ack), 16'h0);

    // R9 return re-enables
    reti = 1; cycle(); reti = 0;
    check("R9 gie set", 16'(rdata[0]), 16'h1);
    cycle();
    check("R9 ack timer0", 16'(vector), 16'h008);
    check("R4 after timer0", 16'(rdata), 16'h4E);

    // R8 stack hold-off
    sf = 1; reti = 1; cycle(); reti = 0;
    for (int k = 0; k < 4; k++) begin
      cycle();
      check("R8 held", 16'(ack), 16'h0);
      check("R8 kept", 16'(rdata), 16'h4F);
    end
    sf = 0; cycle();
    check("R8 served", 16'(ack), 16'h1);
    check("R8 timer1 vector", 16'(vector), 16'h00C);
    check("R8 cleared", 16'(rdata), 16'h0E);

    // R11 event wins over write in same cycle
    we = 1; wd = 8'h00; tov = 2'b10; cycle(); we = 0; tov = 0;
    check("R11 set beats write", 16'(rdata), 16'h40);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tov  = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
      sf   = ($urandom_range(3) == 0);
      reti = ($urandom_range(7) == 0);
      we   = ($urandom_range(15) == 0);
      wd   = 8'($urandom_range(255));
      if ($urandom_range(15) == 0) pin = ~pin;
      cycle();
    end
    we = 0; reti = 0; tov = 0; sf = 0;
    cycles(4);

    done = 1;
    summary();
    $finish;
  end
endmodule